// File: doc/BRIEF.md
# Dual-Clock Shared-Memory Block with Per-Port Read Latency

This block is a word-addressed memory reachable from two fully independent ports, named left and right. Each port has its own clock and its own synchronous reset. A port registers its address, write data and control on its clock. It writes or reads any word, and both ports may use the same word at once. A port is selected only by a pair of enables of opposite polarity. A write/read select picks the operation. An output enable that is not clocked gates the read bus.

Each port's address comes from an internal address register that works as a counter. The register can load the external address, step by one, or clear to zero. A static mode pin, sampled while the port is in reset, sets that port's read latency. In flow mode, data follows the edge that captured the request. In pipelined mode, it follows one edge later. The three-state data bus is modelled as a data-out vector plus a drive flag. Whenever the drive flag is low, data-out reads as zero.

Top module: `dpr_dual_port`

## Requirements
- R1: A port is selected only when its active-low enable is 0 and its active-high enable is 1. If either enable is inactive, the port neither writes nor drives its bus for that request.
- R2: A selected request with the write strobe low (0 = write) stores the data word at the addressed location. The port does not drive its bus for that request.
- R3: In flow mode (mode pin 0 at reset), a selected read drives the addressed word during the clock cycle after the capturing edge. This requires the output enable to be low.
- R4: In pipelined mode (mode pin 1 at reset), a selected read drives its word one clock cycle later than in flow mode.
- R5: While the output enable is high, the drive flag is 0 and data-out is zero. This follows the output enable at once, without waiting for a clock edge.
- R6: The mode pin is sampled only while the port is in reset. Changing it later does not change the read latency.
- R7: The address register clears to 0 when clear is high. Otherwise it loads the external address when load is high, steps by one (wrapping) when increment is high, and holds when none is high. It does this whether or not the port is selected.
- R8: When both ports write the same word on the same edge, the right port's data is kept.
- R9: A read on one port that captures the same word a write on the other port captures on that edge returns the value held before that write.
- R10: After reset neither port drives its bus.
- R11: A word written through one port reads back through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst | input | 1 | Left port synchronous reset, active high |
| l_en_n | input | 1 | Left enable, active low |
| l_en_p | input | 1 | Left enable, active high |
| l_wr_n | input | 1 | Left operation select: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low, not clocked |
| l_pipe | input | 1 | Left read-latency mode: 0 flow, 1 pipelined |
| l_ld | input | 1 | Left address register load from l_addr |
| l_inc | input | 1 | Left address register step by one |
| l_clr | input | 1 | Left address register clear |
| l_addr | input | AW | Left external address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left read data, zero when not driven |
| l_drive | output | 1 | Left bus drive flag |
| r_clk | input | 1 | Right port clock |
| r_rst | input | 1 | Right port synchronous reset, active high |
| r_en_n | input | 1 | Right enable, active low |
| r_en_p | input | 1 | Right enable, active high |
| r_wr_n | input | 1 | Right operation select: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low, not clocked |
| r_pipe | input | 1 | Right read-latency mode: 0 flow, 1 pipelined |
| r_ld | input | 1 | Right address register load from r_addr |
| r_inc | input | 1 | Right address register step by one |
| r_clr | input | 1 | Right address register clear |
| r_addr | input | AW | Right external address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right read data, zero when not driven |
| r_drive | output | 1 | Right bus drive flag |

## Verification
The hardest cases to reach are the same-edge conflicts. One is both ports writing one word. The other is one port reading a word while the other port writes it. The bench runs both ports from one clock and issues both requests in a single step. Each conflict is therefore captured on the same edge, and the word is then read back from both sides. The unclocked output enable is toggled between edges while a read is being driven, in both latency modes. Address-register stepping is checked while the port is deselected, and again at the wrap from the top address to zero.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] aq
);
  // priority: clear, then load, then step
  always_ff @(posedge clk) begin
    if (rst || clr)  aq <= '0;
    else if (ld)     aq <= ext;
    else if (inc)    aq <= aq + 1'b1;
  end
endmodule

// File: rtl/dpr_port_in.sv
module dpr_port_in
  import dpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          en_p,
  input  logic          wr_n,
  input  logic          pipe,
  input  logic          ld,
  input  logic          inc,
  input  logic          clr,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] din,
  output logic          act_q,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output rd_mode_e      mode_q
);
  dpr_addr_ctr #(.AW(AW)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .ld  (ld),
    .inc (inc),
    .ext (addr_in),
    .aq  (addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      din_q  <= '0;
      mode_q <= rd_mode_e'(pipe);
    end else begin
      act_q  <= ~en_n & en_p;
      wr_q   <= ~wr_n;
      din_q  <= din;
    end
  end
endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          l_clk,
  input  logic          l_we,
  input  logic [AW-1:0] l_a,
  input  logic [DW-1:0] l_d,
  output logic [DW-1:0] l_q,
  input  logic          r_clk,
  input  logic          r_we,
  input  logic [AW-1:0] r_a,
  input  logic [DW-1:0] r_d,
  output logic [DW-1:0] r_q
);
  localparam int DEPTH = 1 << AW;

  // each bank has one writer; a word is the XOR of both banks
  logic [DW-1:0] bank_l [DEPTH];
  logic [DW-1:0] bank_r [DEPTH];

  logic l_yield;
  assign l_yield = r_we && (r_a == l_a);

  always_ff @(posedge l_clk) begin
    if (l_we && !l_yield) bank_l[l_a] <= l_d ^ bank_r[l_a];
  end

  always_ff @(posedge r_clk) begin
    if (r_we) bank_r[r_a] <= r_d ^ bank_l[r_a];
  end

  assign l_q = bank_l[l_a] ^ bank_r[l_a];
  assign r_q = bank_l[r_a] ^ bank_r[r_a];
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
  import dpr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  rd_mode_e      mode,
  input  logic          act,
  input  logic          wr,
  input  logic [DW-1:0] q,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          drive
);
  logic          pv_q;
  logic [DW-1:0] pd_q;
  logic          rd_now;
  logic [DW-1:0] rd_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= act & ~wr;
      pd_q <= q;
    end
  end

  always_comb begin
    if (mode == RD_PIPE) begin
      rd_now = pv_q;
      rd_dat = pd_q;
    end else begin
      rd_now = act & ~wr;
      rd_dat = q;
    end
    drive = rd_now & ~oe_n;
    dout  = drive ? rd_dat : '0;
  end
endmodule

// File: rtl/dpr_dual_port.sv
module dpr_dual_port
  import dpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          l_clk,
  input  logic          l_rst,
  input  logic          l_en_n,
  input  logic          l_en_p,
  input  logic          l_wr_n,
  input  logic          l_oe_n,
  input  logic          l_pipe,
  input  logic          l_ld,
  input  logic          l_inc,
  input  logic          l_clr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  output logic [DW-1:0] l_dout,
  output logic          l_drive,
  input  logic          r_clk,
  input  logic          r_rst,
  input  logic          r_en_n,
  input  logic          r_en_p,
  input  logic          r_wr_n,
  input  logic          r_oe_n,
  input  logic          r_pipe,
  input  logic          r_ld,
  input  logic          r_inc,
  input  logic          r_clr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  output logic [DW-1:0] r_dout,
  output logic          r_drive
);
  logic          l_act, l_wr, r_act, r_wr;
  logic [AW-1:0] l_aq, r_aq;
  logic [DW-1:0] l_dq, r_dq, l_q, r_q;
  rd_mode_e      l_mode, r_mode;

  dpr_port_in #(.AW(AW), .DW(DW)) u_in_l (
    .clk(l_clk), .rst(l_rst), .en_n(l_en_n), .en_p(l_en_p), .wr_n(l_wr_n),
    .pipe(l_pipe), .ld(l_ld), .inc(l_inc), .clr(l_clr), .addr_in(l_addr),
    .din(l_din), .act_q(l_act), .wr_q(l_wr), .addr_q(l_aq), .din_q(l_dq),
    .mode_q(l_mode)
  );

  dpr_port_in #(.AW(AW), .DW(DW)) u_in_r (
    .clk(r_clk), .rst(r_rst), .en_n(r_en_n), .en_p(r_en_p), .wr_n(r_wr_n),
    .pipe(r_pipe), .ld(r_ld), .inc(r_inc), .clr(r_clr), .addr_in(r_addr),
    .din(r_din), .act_q(r_act), .wr_q(r_wr), .addr_q(r_aq), .din_q(r_dq),
    .mode_q(r_mode)
  );

  dpr_store #(.AW(AW), .DW(DW)) u_store (
    .l_clk(l_clk), .l_we(l_act & l_wr), .l_a(l_aq), .l_d(l_dq), .l_q(l_q),
    .r_clk(r_clk), .r_we(r_act & r_wr), .r_a(r_aq), .r_d(r_dq), .r_q(r_q)
  );

  dpr_port_out #(.DW(DW)) u_out_l (
    .clk(l_clk), .rst(l_rst), .mode(l_mode), .act(l_act), .wr(l_wr),
    .q(l_q), .oe_n(l_oe_n), .dout(l_dout), .drive(l_drive)
  );

  dpr_port_out #(.DW(DW)) u_out_r (
    .clk(r_clk), .rst(r_rst), .mode(r_mode), .act(r_act), .wr(r_wr),
    .q(r_q), .oe_n(r_oe_n), .dout(r_dout), .drive(r_drive)
  );
endmodule

// File: rtl/dpr_chk.sv
module dpr_chk
  import dpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en_n,
  input logic          en_p,
  input logic          wr_n,
  input logic          oe_n,
  input logic          ld,
  input logic          inc,
  input logic          clr,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] aq,
  input rd_mode_e      mode,
  input logic [DW-1:0] dout,
  input logic          drive
);
  // R5
  oe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!drive && dout == '0));

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n || !en_p) ##1 (en_n || !en_p) |=> !drive);

  // R2
  wr_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && en_p && !wr_n && mode == RD_FLOW) |=> !drive);

  // R7
  ctr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> aq == '0);

  // R7
  ctr_ld_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld) |=> aq == $past(addr));

  // R7
  ctr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && inc) |=> aq == AW'($past(aq) + 1'b1));

  // R7
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && !inc) |=> $stable(aq));
endmodule

bind dpr_dual_port dpr_chk #(.AW(AW), .DW(DW)) u_chk_l (
  .clk(l_clk), .rst(l_rst), .en_n(l_en_n), .en_p(l_en_p), .wr_n(l_wr_n),
  .oe_n(l_oe_n), .ld(l_ld), .inc(l_inc), .clr(l_clr), .addr(l_addr),
  .aq(l_aq), .mode(l_mode), .dout(l_dout), .drive(l_drive)
);

bind dpr_dual_port dpr_chk #(.AW(AW), .DW(DW)) u_chk_r (
  .clk(r_clk), .rst(r_rst), .en_n(r_en_n), .en_p(r_en_p), .wr_n(r_wr_n),
  .oe_n(r_oe_n), .ld(r_ld), .inc(r_inc), .clr(r_clr), .addr(r_addr),
  .aq(r_aq), .mode(r_mode), .dout(r_dout), .drive(r_drive)
);

// File: tb/test_dpr_dual_port.sv
module test_dpr_dual_port;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst;
  logic l_en_n, l_en_p, l_wr_n, l_oe_n, l_pipe, l_ld, l_inc, l_clr;
  logic r_en_n, r_en_p, r_wr_n, r_oe_n, r_pipe, r_ld, r_inc, r_clr;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_din, r_din, l_dout, r_dout;
  logic l_drive, r_drive;

  dpr_dual_port #(.AW(AW), .DW(DW)) i_dpr_dual_port (
    .l_clk(clk), .l_rst(rst), .l_en_n(l_en_n), .l_en_p(l_en_p),
    .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_ld(l_ld),
    .l_inc(l_inc), .l_clr(l_clr), .l_addr(l_addr), .l_din(l_din),
    .l_dout(l_dout), .l_drive(l_drive),
    .r_clk(clk), .r_rst(rst), .r_en_n(r_en_n), .r_en_p(r_en_p),
    .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_ld(r_ld),
    .r_inc(r_inc), .r_clr(r_clr), .r_addr(r_addr), .r_din(r_din),
    .r_dout(r_dout), .r_drive(r_drive)
  );

  typedef struct {
    int          due;
    bit          rd;
    logic [DW-1:0] data;
    string       tag;
  } item_t;

  item_t lq[$];
  item_t rq[$];
  logic [DW-1:0] mem [DEPTH];
  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  int  lcnt = 0, rcnt = 0;
  bit  lmode = 0, rmode = 0;
  bit  lalt = 0, ralt = 0;
  bit  mon_on = 0;
  bit  done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) begin : mon
    item_t it;
    logic  ed;
    if (mon_on) begin
      while (lq.size() > 0 && lq[0].due <= cyc) begin
        it = lq.pop_front();
        ed = it.rd && !l_oe_n;
        check(it.tag, "left", {7'd0, l_drive, l_dout}, {7'd0, ed, ed ? it.data : 8'h00});
      end
      while (rq.size() > 0 && rq[0].due <= cyc) begin
        it = rq.pop_front();
        ed = it.rd && !r_oe_n;
        check(it.tag, "right", {7'd0, r_drive, r_dout}, {7'd0, ed, ed ? it.data : 8'h00});
      end
    end
  end

  // address-source mode: 0 hold, 1 load, 2 step, 3 clear with load and step also high
  task automatic step(input bit ls, input bit lw, input int lm, input int la, input int ldat, input string lt,
                      input bit rs, input bit rw, input int rm, input int ra, input int rdat, input string rt);
    @(negedge clk); #1;
    if (ls) {l_en_n, l_en_p} = 2'b01;
    else begin {l_en_n, l_en_p} = lalt ? 2'b00 : 2'b11; lalt = !lalt; end
    if (rs) {r_en_n, r_en_p} = 2'b01;
    else begin {r_en_n, r_en_p} = ralt ? 2'b00 : 2'b11; ralt = !ralt; end
    l_wr_n = !lw;  r_wr_n = !rw;
    l_ld = (lm == 1 || lm == 3); l_inc = (lm == 2 || lm == 3); l_clr = (lm == 3);
    r_ld = (rm == 1 || rm == 3); r_inc = (rm == 2 || rm == 3); r_clr = (rm == 3);
    l_addr = AW'(la); r_addr = AW'(ra);
    l_din = DW'(ldat); r_din = DW'(rdat);
    if (lm == 3) lcnt = 0; else if (lm == 1) lcnt = la % DEPTH; else if (lm == 2) lcnt = (lcnt + 1) % DEPTH;
    if (rm == 3) rcnt = 0; else if (rm == 1) rcnt = ra % DEPTH; else if (rm == 2) rcnt = (rcnt + 1) % DEPTH;
    lq.push_back('{cyc + (lmode ? 2 : 1), ls && !lw, mem[lcnt], lt});
    rq.push_back('{cyc + (rmode ? 2 : 1), rs && !rw, mem[rcnt], rt});
    if (ls && lw) mem[lcnt] = DW'(ldat);
    if (rs && rw) mem[rcnt] = DW'(rdat);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, "R1", 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic do_reset(input bit lp, input bit rp);
    repeat (3) idle();
    @(negedge clk); #1;
    mon_on = 0;
    rst = 1; l_pipe = lp; r_pipe = rp;
    {l_ld, l_inc, l_clr, r_ld, r_inc, r_clr} = '0;
    repeat (3) @(negedge clk);
    #1;
    rst = 0;
    lmode = lp; rmode = rp; lcnt = 0; rcnt = 0;
    lq.delete(); rq.delete();
    mon_on = 1;
    // R10
    check("R10", "left drive after reset", {15'd0, l_drive}, 16'd0);
    check("R10", "right drive after reset", {15'd0, r_drive}, 16'd0);
  endtask

  // unclocked output enable test on the left port while a read is on the bus
  task automatic oe_async(input int a);
    step(1, 0, 1, a, 0, "R5", 0, 0, 0, 0, 0, "R1");
    if (lmode) idle();
    idle();
    #1 l_oe_n = 1;
    #1 check("R5", "left drive oe high", {7'd0, l_drive, l_dout}, 16'd0);
    l_oe_n = 0;
    #1 check("R5", "left drive oe low", {7'd0, l_drive, l_dout}, {7'd1, mem[a]});
  endtask

  initial begin
    rst = 1;
    {l_en_n, l_en_p, l_wr_n, l_oe_n, l_pipe, l_ld, l_inc, l_clr} = 8'b1010_0000;
    {r_en_n, r_en_p, r_wr_n, r_oe_n, r_pipe, r_ld, r_inc, r_clr} = 8'b1010_1000;
    l_addr = '0; r_addr = '0; l_din = '0; r_din = '0;
    foreach (mem[i]) mem[i] = '0;

    do_reset(0, 1);   // left flow, right pipelined

    // R2: fill every word through the left port
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 1, i, (i * 37 + 11) & 8'hFF, "R2", 0, 0, 0, 0, 0, "R1");

    // R3 / R4: reads in both latencies, including back-to-back
    for (int i = 0; i < 12; i++)
      step(1, 0, 1, i * 3, 0, "R3", 1, 0, 1, 255 - i * 5, 0, "R4");

    // R11: write on one side, read on the other
    step(0, 0, 0, 0, 0, "R1", 1, 1, 1, 20, 8'hC3, "R2");
    step(1, 0, 1, 20, 0, "R11", 0, 0, 0, 0, 0, "R1");
    step(1, 1, 1, 21, 8'h3C, "R2", 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1", 1, 0, 1, 21, 0, "R11");

    // R8: both write one word on the same edge
    step(1, 1, 1, 40, 8'hAA, "R8", 1, 1, 1, 40, 8'h55, "R8");
    step(1, 0, 1, 40, 0, "R8", 1, 0, 1, 40, 0, "R8");

    // R9: read against a write on the other port
    step(1, 0, 1, 50, 0, "R9", 1, 1, 1, 50, 8'h77, "R9");
    step(1, 1, 1, 60, 8'h99, "R9", 1, 0, 1, 60, 0, "R9");
    step(1, 0, 1, 60, 0, "R9", 1, 0, 1, 50, 0, "R9");

    // R1: writes while deselected, both enable forms, then read back
    step(0, 1, 1, 70, 8'h01, "R1", 0, 1, 1, 71, 8'h02, "R1");
    step(0, 1, 1, 70, 8'h03, "R1", 0, 1, 1, 71, 8'h04, "R1");
    step(0, 0, 1, 70, 0, "R1", 0, 0, 1, 71, 0, "R1");
    step(1, 0, 1, 70, 0, "R1", 1, 0, 1, 71, 0, "R1");

    // R5: reads with output enable high on the bus cycle
    l_oe_n = 1; r_oe_n = 1;
    step(1, 0, 1, 80, 0, "R5", 1, 0, 1, 81, 0, "R5");
    step(1, 0, 1, 82, 0, "R5", 1, 0, 1, 83, 0, "R5");
    idle(); idle();
    l_oe_n = 0; r_oe_n = 0;
    oe_async(90);

    // R7: address register steps while deselected, clear wins, wrap
    step(0, 0, 1, 10, 0, "R7", 0, 0, 1, 200, 0, "R7");
    step(0, 0, 2, 0, 0, "R7", 0, 0, 2, 0, 0, "R7");
    step(0, 0, 2, 0, 0, "R7", 1, 0, 2, 0, 0, "R7");
    step(1, 0, 0, 0, 0, "R7", 1, 0, 0, 0, 0, "R7");
    step(1, 0, 3, 99, 0, "R7", 1, 0, 3, 99, 0, "R7");
    step(1, 0, 1, 255, 0, "R7", 0, 0, 0, 0, 0, "R1");
    step(1, 0, 2, 0, 0, "R7", 0, 0, 0, 0, 0, "R1");

    // R6: flip mode pins without reset; latency must not change
    l_pipe = !lmode; r_pipe = !rmode;
    for (int i = 0; i < 4; i++)
      step(1, 0, 1, 100 + i, 0, "R6", 1, 0, 1, 110 + i, 0, "R6");

    // swap latencies through reset, memory contents kept
    do_reset(1, 0);
    for (int i = 0; i < 6; i++)
      step(1, 0, 1, 120 + i, 0, "R4", 1, 0, 1, 130 + i, 0, "R3");
    step(1, 1, 1, 140, 8'h5A, "R2", 1, 0, 1, 140, 0, "R9");
    step(1, 0, 1, 140, 0, "R4", 1, 0, 1, 140, 0, "R11");
    step(1, 1, 1, 141, 8'h11, "R8", 1, 1, 1, 141, 8'h22, "R8");
    step(1, 0, 1, 141, 0, "R8", 1, 0, 1, 141, 0, "R8");
    oe_async(141);

    repeat (4) idle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule